// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host CPU a path to registers in a slow or always-on domain that the host cannot address directly. The host sees four word registers: a control register, a direction/byte-lane register, a target-address register and a data register. Software programs the direction, the address and (for a write) the data. It then writes a go command to the control register and polls that register until it reads zero. After a read, the data register holds the value fetched from the target.

Toward the target the bridge drives a request/acknowledge port of variable latency. One request is raised per transfer. Address, write flag, byte lanes and write data are held steady until the target answers with a single-cycle acknowledge. For a read, the returned word is captured on that acknowledge. While a transfer is outstanding, every host write is dropped, so a transfer in progress cannot be disturbed.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset the control register reads 0, the direction/byte-lane, address and data registers read 0, and `tgt_req` is low.
- R2: A host write to offset 0x00 with bit 0 of the write data set, while idle, raises `tgt_req` in the cycle after the write edge. The target port carries the programmed address, write flag, lanes and data.
- R3: The control register (offset 0x00) reads 1 from the cycle after a transfer starts until the acknowledge edge, and reads 0 afterwards.
- R4: With offset 0x04 holding 0x00, a transfer is a read (`tgt_we` low). The `tgt_rdata` present on the acknowledge cycle then reads back from offset 0x0C.
- R5: With offset 0x04 holding 0xF1, a transfer is a write of the offset-0x0C value to all four bytes (`tgt_we` high, `tgt_be` = 4'hF).
- R6: In offset 0x04, bit 0 selects write, bits 7:4 drive `tgt_be` (bit 4 = byte 0), and bits 3:1 are not stored (they read 0). A write updates only the enabled bytes of the target word.
- R7: While a transfer is outstanding, host writes to offsets 0x00, 0x04, 0x08 and 0x0C have no effect: no extra request and no register change.
- R8: While `tgt_req` is high and `tgt_ack` low, `tgt_req`, `tgt_addr`, `tgt_we`, `tgt_be` and `tgt_wdata` stay unchanged in the next cycle.
- R9: A host read strobe returns the addressed register on `host_rdata` one cycle later. The address register keeps the low TADDR_W bits of the written value, zero-extended.
- R10: A host write to offset 0x00 with bit 0 clear starts no transfer.
- R11: `tgt_req` falls in the cycle after the acknowledge, so each transfer issues exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HADDR_W | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| tgt_req | output | 1 | Target request, held until acknowledge |
| tgt_we | output | 1 | Target write flag |
| tgt_be | output | 4 | Target byte enables |
| tgt_addr | output | TADDR_W | Target register address |
| tgt_wdata | output | 32 | Target write data |
| tgt_ack | input | 1 | One-cycle target acknowledge |
| tgt_rdata | input | 32 | Target read data, valid with acknowledge |

## Verification
The bench builds the bridge with TADDR_W = 6, so the behavioural target holds just 64 words. Random traffic therefore often revisits a location after a partial-lane write, and the byte merging and read-back of earlier results get checked against a shadow copy. HADDR_W stays at 4, which keeps every address bit in the decode. Forced acknowledge delays of zero and of many cycles bring the immediate-answer case and the long busy window (used to fire host writes that must be dropped) within reach.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  // word index = host_addr[3:2]
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_MODE = 2'd1;
  localparam logic [1:0] IDX_ADDR = 2'd2;
  localparam logic [1:0] IDX_DATA = 2'd3;

  typedef enum logic {XS_IDLE, XS_WAIT} xfer_state_t;
endpackage

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
  import ibr_pkg::*;
#(
  parameter int HADDR_W = 4,
  parameter int TADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [HADDR_W-1:0]  host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  output logic [WORD_W-1:0]   host_rdata,
  input  logic                busy,
  input  logic                cap_en,
  input  logic [WORD_W-1:0]   cap_data,
  output logic                start,
  output logic                mode_wr,
  output logic [LANES-1:0]    mode_be,
  output logic [TADDR_W-1:0]  addr_q,
  output logic [WORD_W-1:0]   data_q
);
  logic       aligned;
  logic [1:0] idx;
  logic       wr_ok;

  assign aligned = (host_addr[1:0] == 2'b00);
  assign idx     = host_addr[3:2];
  assign wr_ok   = host_wr && aligned && !busy;
  assign start   = wr_ok && (idx == IDX_CTRL) && host_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_wr <= 1'b0;
      mode_be <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (wr_ok && idx == IDX_MODE) begin
        mode_wr <= host_wdata[0];
        mode_be <= host_wdata[7:4];
      end
      if (wr_ok && idx == IDX_ADDR) addr_q <= host_wdata[TADDR_W-1:0];
      if (cap_en)                   data_q <= cap_data;
      else if (wr_ok && idx == IDX_DATA) data_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (!aligned) host_rdata <= '0;
      else begin
        case (idx)
          IDX_CTRL: host_rdata <= {{(WORD_W-1){1'b0}}, busy};
          IDX_MODE: host_rdata <= {{(WORD_W-8){1'b0}}, mode_be, 3'b000, mode_wr};
          IDX_ADDR: host_rdata <= WORD_W'(addr_q);
          default:  host_rdata <= data_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/ibr_xfer_engine.sv
module ibr_xfer_engine
  import ibr_pkg::*;
#(
  parameter int TADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               mode_wr,
  input  logic [LANES-1:0]   mode_be,
  input  logic [TADDR_W-1:0] addr_q,
  input  logic [WORD_W-1:0]  data_q,
  output logic               busy,
  output logic               cap_en,
  output logic [WORD_W-1:0]  cap_data,
  output logic               tgt_req,
  output logic               tgt_we,
  output logic [LANES-1:0]   tgt_be,
  output logic [TADDR_W-1:0] tgt_addr,
  output logic [WORD_W-1:0]  tgt_wdata,
  input  logic               tgt_ack,
  input  logic [WORD_W-1:0]  tgt_rdata
);
  xfer_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XS_IDLE;
      tgt_req   <= 1'b0;
      tgt_we    <= 1'b0;
      tgt_be    <= '0;
      tgt_addr  <= '0;
      tgt_wdata <= '0;
    end else begin
      case (state)
        XS_IDLE: if (start) begin
          state     <= XS_WAIT;
          tgt_req   <= 1'b1;
          tgt_we    <= mode_wr;
          tgt_be    <= mode_be;
          tgt_addr  <= addr_q;
          tgt_wdata <= data_q;
        end
        default: if (tgt_ack) begin
          state   <= XS_IDLE;
          tgt_req <= 1'b0;
        end
      endcase
    end
  end

  assign busy     = (state == XS_WAIT);
  assign cap_en   = busy && tgt_ack && !tgt_we;
  assign cap_data = tgt_rdata;
endmodule

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge
  import ibr_pkg::*;
#(
  parameter int HADDR_W = 4,
  parameter int TADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  output logic               tgt_req,
  output logic               tgt_we,
  output logic [3:0]         tgt_be,
  output logic [TADDR_W-1:0] tgt_addr,
  output logic [31:0]        tgt_wdata,
  input  logic               tgt_ack,
  input  logic [31:0]        tgt_rdata
);
  logic               start;
  logic               busy;
  logic               cap_en;
  logic [WORD_W-1:0]  cap_data;
  logic               mode_wr;
  logic [LANES-1:0]   mode_be;
  logic [TADDR_W-1:0] addr_q;
  logic [WORD_W-1:0]  reg_data;

  ibr_host_regs #(.HADDR_W(HADDR_W), .TADDR_W(TADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .cap_en(cap_en), .cap_data(cap_data),
    .start(start), .mode_wr(mode_wr), .mode_be(mode_be),
    .addr_q(addr_q), .data_q(reg_data)
  );

  ibr_xfer_engine #(.TADDR_W(TADDR_W)) u_engine (
    .clk(clk), .rst(rst), .start(start),
    .mode_wr(mode_wr), .mode_be(mode_be), .addr_q(addr_q), .data_q(reg_data),
    .busy(busy), .cap_en(cap_en), .cap_data(cap_data),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_be(tgt_be),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
  parameter int HADDR_W = 4,
  parameter int TADDR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic [HADDR_W-1:0] host_addr,
  input logic               go_bit,
  input logic               tgt_req,
  input logic               tgt_we,
  input logic [3:0]         tgt_be,
  input logic [TADDR_W-1:0] tgt_addr,
  input logic [31:0]        tgt_wdata,
  input logic               tgt_ack,
  input logic [31:0]        tgt_rdata,
  input logic [31:0]        reg_data
);
  logic ctrl_wr, data_wr;
  assign ctrl_wr = host_wr && (host_addr == HADDR_W'(0));
  assign data_wr = host_wr && (host_addr == HADDR_W'(12));

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tgt_req); // R1

  AST_START_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && go_bit && !tgt_req) |=> tgt_req); // R2

  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && tgt_ack && !tgt_we) |=> (reg_data == $past(tgt_rdata))); // R4

  AST_BUSY_DATA_LOCK: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && !tgt_ack && data_wr) |=> $stable(reg_data)); // R7

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_we)
                               && $stable(tgt_be) && $stable(tgt_wdata))); // R8

  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !go_bit && !tgt_req) |=> !tgt_req); // R10

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && tgt_ack) |=> !tgt_req); // R11
endmodule

bind indirect_reg_bridge ibr_checker #(.HADDR_W(HADDR_W), .TADDR_W(TADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .go_bit(host_wdata[0]), .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_be(tgt_be),
  .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack),
  .tgt_rdata(tgt_rdata), .reg_data(reg_data)
);

// File: tb/indirect_reg_bridge_tb.sv
module indirect_reg_bridge_tb;
  localparam int TA    = 6;
  localparam int DEPTH = 1 << TA;
  localparam logic [3:0] O_CTRL = 4'h0, O_MODE = 4'h4, O_ADDR = 4'h8, O_DATA = 4'hC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic tgt_req, tgt_we, tgt_ack;
  logic [3:0] tgt_be;
  logic [TA-1:0] tgt_addr;
  logic [31:0] tgt_wdata, tgt_rdata;

  int checks = 0, failures = 0;
  int req_count = 0, hold_errs = 0, drop_errs = 0;
  int force_delay = -1;
  bit done = 1'b0;
  logic [31:0] tmem [DEPTH];
  logic [31:0] shadow [DEPTH];

  always #4 clk = ~clk;

  indirect_reg_bridge #(.HADDR_W(4), .TADDR_W(TA)) u_dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tgt_req(tgt_req), .tgt_we(tgt_we), .tgt_be(tgt_be), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  function automatic logic [31:0] init_word(int i);
    return 32'hA500_0000 ^ (i * 32'h0001_0203);
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural target with random response delay
  initial begin
    logic [TA-1:0] s_addr; logic s_we; logic [3:0] s_be; logic [31:0] s_wd;
    int dly; bit acked;
    acked = 1'b0;
    tgt_ack = 1'b0; tgt_rdata = '0;
    for (int i = 0; i < DEPTH; i++) tmem[i] = init_word(i);
    forever begin
      @(negedge clk);
      tgt_ack = 1'b0;
      if (acked) begin
        if (tgt_req !== 1'b0) drop_errs++;
        acked = 1'b0;
      end else if (tgt_req === 1'b1 && !rst) begin
        req_count++;
        s_addr = tgt_addr; s_we = tgt_we; s_be = tgt_be; s_wd = tgt_wdata;
        dly = (force_delay >= 0) ? force_delay : int'($urandom_range(0, 6));
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          if (tgt_req !== 1'b1 || tgt_addr !== s_addr || tgt_we !== s_we ||
              tgt_be !== s_be || tgt_wdata !== s_wd) hold_errs++;
        end
        if (s_we) tmem[s_addr] = merge(tmem[s_addr], s_wd, s_be);
        else      tgt_rdata = tmem[s_addr];
        tgt_ack = 1'b1;
        acked = 1'b1;
      end
    end
  end

  // tasks start and end at a negedge
  task automatic hw(logic [3:0] a, logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(logic [3:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v; bit ok;
    ok = 1'b0;
    for (int n = 0; n < 400; n++) begin
      hr(O_CTRL, v);
      if (v == 32'd0) begin ok = 1'b1; break; end
    end
    chk("R3 control returns to zero", {31'd0, ok}, 32'd1);
  endtask

  task automatic xfer(bit wr, logic [TA-1:0] a, logic [31:0] v, logic [3:0] be);
    logic [31:0] got;
    hw(O_MODE, {24'd0, be, 3'b000, wr});
    hw(O_ADDR, 32'(a));
    if (wr) hw(O_DATA, v);
    hw(O_CTRL, 32'd1);
    wait_idle();
    if (wr) shadow[a] = merge(shadow[a], v, be);
    else begin
      hr(O_DATA, got);
      chk("R4 read data", got, shadow[a]);
    end
  endtask

  initial begin
    logic [31:0] v; int rc;
    void'($urandom(32'h1BADB002));
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_word(i);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R1 req after reset", {31'd0, tgt_req}, 32'd0);
    hr(O_CTRL, v); chk("R1 control", v, 32'd0);
    hr(O_MODE, v); chk("R1 mode", v, 32'd0);
    hr(O_ADDR, v); chk("R1 address", v, 32'd0);
    hr(O_DATA, v); chk("R1 data", v, 32'd0);

    hw(O_ADDR, 32'hFFFF_FF2A); hr(O_ADDR, v); chk("R9 address readback", v, 32'h2A);
    hw(O_MODE, 32'hFFFF_FFF1); hr(O_MODE, v); chk("R9 mode readback F1", v, 32'hF1);
    hw(O_MODE, 32'h0000_005E); hr(O_MODE, v); chk("R6 mode bits 3:1 dropped", v, 32'h50);

    rc = req_count;
    hw(O_CTRL, 32'h2); @(negedge clk); @(negedge clk);
    chk("R10 no request", {31'd0, tgt_req}, 32'd0);
    chk("R10 request count", 32'(req_count), 32'(rc));
    hr(O_CTRL, v); chk("R10 control idle", v, 32'd0);

    // long directed write, with host writes during the busy window
    force_delay = 12;
    hw(O_MODE, 32'hF1); hw(O_ADDR, 32'd5); hw(O_DATA, 32'hDEAD_BEEF);
    rc = req_count;
    hw(O_CTRL, 32'd1);
    chk("R2 req raised", {31'd0, tgt_req}, 32'd1);
    chk("R2 target address", 32'(tgt_addr), 32'd5);
    chk("R5 write flag", {31'd0, tgt_we}, 32'd1);
    chk("R5 lanes", {28'd0, tgt_be}, 32'hF);
    chk("R5 write data", tgt_wdata, 32'hDEAD_BEEF);
    hr(O_CTRL, v); chk("R3 control busy", v, 32'd1);
    hw(O_ADDR, 32'd9); hw(O_DATA, 32'h1234_5678); hw(O_MODE, 32'h00); hw(O_CTRL, 32'd1);
    wait_idle();
    shadow[5] = 32'hDEAD_BEEF;
    chk("R7 single request", 32'(req_count - rc), 32'd1);
    hr(O_ADDR, v); chk("R7 address kept", v, 32'd5);
    hr(O_MODE, v); chk("R7 mode kept", v, 32'hF1);
    hr(O_DATA, v); chk("R7 data kept", v, 32'hDEAD_BEEF);

    force_delay = 0;
    xfer(1'b0, 6'd5, '0, 4'h0);
    xfer(1'b1, 6'd7, 32'h1122_3344, 4'b0101);
    xfer(1'b0, 6'd7, '0, 4'h0);
    chk("R6 partial merge", shadow[7], merge(init_word(7), 32'h1122_3344, 4'b0101));
    xfer(1'b1, 6'd7, 32'hFFFF_FFFF, 4'b0000);
    xfer(1'b0, 6'd7, '0, 4'h0);

    force_delay = -1;
    for (int t = 0; t < 80; t++) begin
      bit wr = 1'($urandom_range(0, 1));
      logic [TA-1:0] a = TA'($urandom_range(0, DEPTH - 1));
      logic [3:0] be = ($urandom_range(0, 3) == 0) ? 4'hF : 4'($urandom_range(0, 15));
      xfer(wr, a, $urandom, be);
    end
    for (int i = 0; i < 8; i++) xfer(1'b0, TA'(i), '0, 4'h0);

    chk("R8 port held while waiting", 32'(hold_errs), 32'd0);
    chk("R11 req drops after ack", 32'(drop_errs), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule